// File: doc/BRIEF.md
# DDR Controller Register Bring-up Sequencer

This block brings an external-memory controller out of reset through that controller's APB3 configuration port. After reset it waits for the controller's PLL to report lock. It then issues one APB write for each entry of a built-in register table, one transfer at a time. Each transfer follows the slave's PREADY, so wait states are honoured.

When the last entry has been written, the block waits a settling time. That time is a count of init-clock cycles, taken from an input. A count of 10,000 gives 200 us at a 50 MHz clock, and 20,000 gives 400 us. After the settling time the block raises a done flag that stays high until reset.

An error response from the slave ends the sequence with a sticky error flag instead. If the PLL loses lock before the block finishes, the sequence starts again from the first table entry once lock returns.

The block is clocked by the APB clock and reset by the active-low APB reset. It drives only the write side of the bus. Addresses are word addresses, meaning byte-address bits [10:2], so the two low byte-address bits are never driven.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted and on release, psel, penable, pwrite, init_done and init_error are all low.
- R2: No transfer starts, and psel stays low, in any cycle after reset in which pll_lock has been low at the preceding clock edge, until done.
- R3: Each transfer has a setup cycle (psel=1, penable=0) followed by an access phase (psel=1, penable=1). The access phase is held until pready is sampled high. The setup phase of the next transfer starts in the following cycle.
- R4: The k-th transfer (k counted from 0) carries the word address paddr = ADDR_BASE + k, where ADDR_BASE defaults to 16, and the data pwdata = {k[7:0] ^ 8'h5A, ~k[7:0]}. Address and data stay stable for the whole transfer.
- R5: pwrite is high in every cycle in which psel is high and low otherwise.
- R6: settle_cycles is sampled at the clock edge that completes the final transfer. When the sampled value N is at least 1, init_done rises exactly N clock edges after that completion edge.
- R7: A completing transfer with pslverr high sets init_error, which stays high until reset. No further transfer starts after it, and init_done never rises.
- R8: If pll_lock is low at any clock edge before done, any transfer in progress is dropped and the block returns to waiting for lock. Once lock returns, the table restarts from entry 0.
- R9: Once high, init_done stays high until reset, whatever pll_lock does.
- R10: When the value of settle_cycles sampled at the edge that completes the final transfer is 0, init_done rises at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock, also the settling time base |
| presetn | input | 1 | Active-low asynchronous reset |
| pll_lock | input | 1 | Controller PLL lock indication |
| settle_cycles | input | SETTLE_W | Settling time in clock cycles |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable (access phase) |
| pwrite | output | 1 | APB write strobe |
| paddr | output | ADDR_W | Word address (byte address bits [10:2]) |
| pwdata | output | DATA_W | APB write data |
| pready | input | 1 | Slave ready, ends the access phase |
| pslverr | input | 1 | Slave error, valid together with pready |
| init_done | output | 1 | Sticky bring-up complete flag |
| init_error | output | 1 | Sticky slave-error flag |

## Verification
The hardest situation to reach from the ports is a loss of lock that falls in the middle of a transfer that the slave is stalling. The bench therefore runs a sequence in which pready comes from a pseudo-random pattern, and it drops pll_lock while a mid-table address is on the bus. It then checks that the restart begins at the first entry. An error response is forced by making pslverr high only when a chosen address completes. Long settling counts of 10,000 and 20,000 cycles run against a per-cycle model that counts the edges independently.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [2:0] {
    ST_LOCKWAIT = 3'd0,
    ST_SETUP    = 3'd1,
    ST_ACCESS   = 3'd2,
    ST_SETTLE   = 3'd3,
    ST_DONE     = 3'd4,
    ST_FAIL     = 3'd5
  } seq_state_e;

  // Value written by table entry k: upper byte is k xor 0x5A, lower byte is ~k.
  function automatic logic [15:0] entry_word(input int k);
    logic [7:0] b;
    b = k[7:0];
    return {b ^ 8'h5A, ~b};
  endfunction

endpackage

// File: rtl/ddr_init_table.sv
module ddr_init_table #(
  parameter int NUM_REGS  = 8,
  parameter int IDX_W     = 3,
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 16,
  parameter int ADDR_BASE = 16
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int SLOTS = 1 << IDX_W;

  logic [ADDR_W-1:0] addr_arr [SLOTS];
  logic [DATA_W-1:0] data_arr [SLOTS];

  for (genvar k = 0; k < SLOTS; k++) begin : g_entry
    if (k < NUM_REGS) begin : g_used
      assign addr_arr[k] = ADDR_W'(ADDR_BASE + k);
      assign data_arr[k] = DATA_W'(ddr_init_pkg::entry_word(k));
    end else begin : g_pad
      assign addr_arr[k] = '0;
      assign data_arr[k] = '0;
    end
  end

  assign addr_o = addr_arr[idx_i];
  assign data_o = data_arr[idx_i];
endmodule

// File: rtl/ddr_settle_timer.sv
module ddr_settle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] value_i,
  input  logic             run_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (load_i)                  cnt_q <= value_i;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  // High in the cycle whose closing edge is the N-th one after the load.
  assign last_o = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int NUM_REGS  = 8,
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 16,
  parameter int ADDR_BASE = 16,
  parameter int SETTLE_W  = 16
) (
  input  logic                pclk,
  input  logic                presetn,
  input  logic                pll_lock,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                psel,
  output logic                penable,
  output logic                pwrite,
  output logic [ADDR_W-1:0]   paddr,
  output logic [DATA_W-1:0]   pwdata,
  input  logic                pready,
  input  logic                pslverr,
  output logic                init_done,
  output logic                init_error
);
  import ddr_init_pkg::*;

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             xfer_end, final_xfer, timer_load, timer_last;

  ddr_init_table #(
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .ADDR_BASE(ADDR_BASE)
  ) u_table (
    .idx_i (idx_q),
    .addr_o(paddr),
    .data_o(pwdata)
  );

  assign xfer_end   = (state_q == ST_ACCESS) && pready;
  assign final_xfer = xfer_end && !pslverr && (idx_q == LAST_IDX);
  assign timer_load = final_xfer && pll_lock;

  ddr_settle_timer #(.CNT_W(SETTLE_W)) u_timer (
    .clk    (pclk),
    .rst_n  (presetn),
    .load_i (timer_load),
    .value_i(settle_cycles),
    .run_i  (state_q == ST_SETTLE),
    .last_o (timer_last)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    if (state_q != ST_DONE && state_q != ST_FAIL && !pll_lock) begin
      state_d = ST_LOCKWAIT;
      idx_d   = '0;
    end else begin
      unique case (state_q)
        ST_LOCKWAIT: begin
          state_d = ST_SETUP;
          idx_d   = '0;
        end
        ST_SETUP:  state_d = ST_ACCESS;
        ST_ACCESS: begin
          if (xfer_end) begin
            if (pslverr)                   state_d = ST_FAIL;
            else if (final_xfer)           state_d = (settle_cycles == '0) ? ST_DONE : ST_SETTLE;
            else begin
              state_d = ST_SETUP;
              idx_d   = idx_q + 1'b1;
            end
          end
        end
        ST_SETTLE: if (timer_last) state_d = ST_DONE;
        ST_DONE:   state_d = ST_DONE;
        ST_FAIL:   state_d = ST_FAIL;
        default:   state_d = ST_LOCKWAIT;
      endcase
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      state_q <= ST_LOCKWAIT;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign psel       = (state_q == ST_SETUP) || (state_q == ST_ACCESS);
  assign penable    = (state_q == ST_ACCESS);
  assign pwrite     = psel;
  assign init_done  = (state_q == ST_DONE);
  assign init_error = (state_q == ST_FAIL);
endmodule

// File: rtl/ddr_init_seq_checker.sv
module ddr_init_seq_checker #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input logic              pclk,
  input logic              presetn,
  input logic              pll_lock,
  input logic              psel,
  input logic              penable,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic              pready,
  input logic              init_done,
  input logic              init_error
);
  p_no_start_unlocked_r2: assert property (@(posedge pclk) disable iff (!presetn)
    (!pll_lock && !init_done) |=> !psel);

  p_setup_then_access_r3: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !penable && pll_lock) |=> (psel && penable));

  p_access_hold_r3: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && penable && !pready && pll_lock) |=> (psel && penable && $stable(paddr) && $stable(pwdata)));

  p_error_sticky_r7: assert property (@(posedge pclk) disable iff (!presetn)
    init_error |=> (init_error && !psel && !init_done));

  p_done_sticky_r9: assert property (@(posedge pclk) disable iff (!presetn)
    init_done |=> (init_done && !psel));

  p_enable_needs_sel_r3: assert property (@(posedge pclk) disable iff (!presetn)
    penable |-> psel);
endmodule

bind ddr_init_seq ddr_init_seq_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checker (
  .pclk      (pclk),
  .presetn   (presetn),
  .pll_lock  (pll_lock),
  .psel      (psel),
  .penable   (penable),
  .paddr     (paddr),
  .pwdata    (pwdata),
  .pready    (pready),
  .init_done (init_done),
  .init_error(init_error)
);

// File: tb/ddr_init_seq_test.sv
module ddr_init_seq_test;
  localparam int NREG = 8;
  localparam int BASE = 16;

  logic        clk = 1'b0;
  logic        rstn = 1'b0;
  logic        lock = 1'b0;
  logic [15:0] settle = 16'd5;
  logic        psel, penable, pwrite, pready, pslverr, done, err;
  logic [8:0]  paddr;
  logic [15:0] pwdata;

  int n_chk = 0;
  int n_fail = 0;
  bit wait_mode = 1'b0;
  int err_at = -1;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference: phase 0 idle,1 setup,2 access,3 settling,4 done,5 failed
  int m_phase = 0;
  int m_entry = 0;
  int m_left = 0;

  always #10 clk = ~clk;

  ddr_init_seq uut (
    .pclk(clk), .presetn(rstn), .pll_lock(lock), .settle_cycles(settle),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .pready(pready), .pslverr(pslverr), .init_done(done), .init_error(err)
  );

  function automatic logic [15:0] exp_word(int k);
    logic [7:0] b;
    b = k[7:0];
    return {b ^ 8'h5A, ~b};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      m_phase = 0; m_entry = 0; m_left = 0;
    end else if (m_phase < 4 && !lock) begin
      m_phase = 0; m_entry = 0;
    end else begin
      case (m_phase)
        0: begin m_phase = 1; m_entry = 0; end
        1: m_phase = 2;
        2: if (pready) begin
             if (pslverr) m_phase = 5;
             else if (m_entry == NREG - 1) begin
               m_left = int'(settle);
               m_phase = (m_left == 0) ? 4 : 3;
             end else begin
               m_entry++; m_phase = 1;
             end
           end
        3: begin m_left--; if (m_left == 0) m_phase = 4; end
        default: ;
      endcase
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstn) begin
      chk("R3 psel", psel, (m_phase == 1 || m_phase == 2));
      chk("R3 penable", penable, (m_phase == 2));
      chk("R5 pwrite", pwrite, (m_phase == 1 || m_phase == 2));
      if (m_phase == 1 || m_phase == 2) begin
        chk("R4 paddr", paddr, BASE + m_entry);
        chk("R4 pwdata", pwdata, exp_word(m_entry));
      end
      chk("R6 init_done", done, (m_phase == 4));
      chk("R7 init_error", err, (m_phase == 5));
    end
  end

  // slave response generator
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    pready  <= wait_mode ? lfsr[0] : 1'b1;
    pslverr <= (err_at >= 0) && psel && penable && (paddr == 9'(BASE + err_at));
  end

  task automatic do_reset();
    rstn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 psel", psel, 0);
    chk("R1 penable", penable, 0);
    chk("R1 pwrite", pwrite, 0);
    chk("R1 done", done, 0);
    chk("R1 error", err, 0);
    rstn = 1'b1;
  endtask

  task automatic wait_end(input int limit);
    for (int i = 0; i < limit && !done && !err; i++) @(negedge clk);
  endtask

  initial begin
    pready = 1'b1; pslverr = 1'b0;
    // sequence 1: lock gating, 200 us settling count
    settle = 16'd10000;
    do_reset();
    repeat (6) begin
      @(negedge clk);
      chk("R2 no select before lock", psel, 0);
    end
    lock = 1'b1;
    wait_end(12000);
    chk("R6 done after 10000 cycles", done, 1);
    lock = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 done held without lock", done, 1);
    chk("R9 no select after done", psel, 0);

    // sequence 2: wait states, 400 us settling count
    settle = 16'd20000; wait_mode = 1'b1;
    do_reset();
    @(negedge clk); lock = 1'b1;
    wait_end(22000);
    chk("R6 done after 20000 cycles", done, 1);

    // sequence 3: zero settling count
    settle = 16'd0; wait_mode = 1'b0;
    do_reset();
    @(negedge clk); lock = 1'b1;
    while (!(penable && paddr == 9'(BASE + NREG - 1))) @(negedge clk);
    @(negedge clk);
    chk("R10 done at completion edge", done, 1);

    // sequence 4: lock loss mid-table with wait states
    settle = 16'd7; wait_mode = 1'b1;
    do_reset();
    @(negedge clk); lock = 1'b1;
    while (!(psel && paddr == 9'(BASE + 4))) @(negedge clk);
    lock = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R8 transfer dropped", psel, 0);
    lock = 1'b1;
    while (!psel) @(negedge clk);
    chk("R8 restart at first entry", paddr, BASE);
    wait_end(500);
    chk("R8 done after restart", done, 1);

    // sequence 5: slave error
    settle = 16'd3; wait_mode = 1'b0; err_at = 3;
    do_reset();
    @(negedge clk); lock = 1'b1;
    wait_end(500);
    chk("R7 error raised", err, 1);
    repeat (30) @(negedge clk);
    chk("R7 error sticky", err, 1);
    chk("R7 never done", done, 0);
    chk("R7 no further select", psel, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule